// File: doc/BRIEF.md
# Sector Lock Command Sequencer

This block watches the write cycles on a flash model's bus and keeps a per-sector write-protection map. A lock or unlock command takes three writes:

- two opening writes of the byte 60h, at any address;
- a third 60h write whose address selects the sector, with one address bit choosing lock or unlock.

While the sequencer stays in that third-cycle state, each further 60h write relocks or unlocks another sector. No new opening writes are needed.

The exit command F0h leaves the sequence at any address. While the erase-busy flag is high, the exit command is ignored. Any other unexpected write drops the sequencer back to idle and leaves the map unchanged.

A write-protect pin, active low, forces the boot sectors at the outer end of the sector range to read as not writable. This does not alter their stored lock bits. The per-sector write-allowed vector combines the stored map with that override.

Top module: `sector_guard`

## Requirements
- R1: After reset every stored lock bit is 1 (locked) and every write-allowed bit is 0.
- R2: Two strobed writes of data 60h at any address, followed by a third strobed 60h write, update the lock bit of sector `wr_addr[9:7]` (default parameters). The update is visible after the clock edge that samples the third write.
- R3: In the applying write, `wr_addr[6]` = 0 sets the sector's lock bit to 1, and `wr_addr[6]` = 1 clears it to 0.
- R4: After the third cycle, each further 60h write applies to its own sector without repeating the two opening writes.
- R5: A strobed F0h write with `erase_busy` = 0 returns the sequencer to idle from any state. A following 60h write then counts as an opening write and changes no lock bit.
- R6: A strobed F0h write with `erase_busy` = 1 is ignored. The sequencer keeps its state, so a following 60h write in the applying state still updates a lock bit.
- R7: A strobed write of any data other than 60h or F0h returns the sequencer to idle and leaves every lock bit unchanged.
- R8: While `wp_n` = 0, the write-allowed bits of the top two sectors (6 and 7) are 0 with no clock delay. Their stored lock bits are unchanged, so after `wp_n` returns to 1 their write-allowed bits again follow the lock bits.
- R9: For every sector, write-allowed = NOT lock bit AND NOT (sector is forced by `wp_n`).
- R10: Bus activity with `wr_en` = 0 changes neither the lock map nor the sequencer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 10 | Write address; bits 9:7 pick the sector, bit 6 is the lock polarity |
| wr_data | input | 8 | Write data byte (command code) |
| wp_n | input | 1 | Write-protect pin, low forces boot sectors unwritable |
| erase_busy | input | 1 | High while an erase is running; exit command is then ignored |
| lock_map | output | 8 | Stored lock bit per sector, 1 = locked |
| wr_ok | output | 8 | Per-sector write-allowed result |

## Verification
A lock bit changes on the same rising edge that samples the applying write. The bench therefore drives each write on a falling edge and compares the map on the next falling edge, one register stage later. The write-allowed vector has no register between `wp_n` and the output, so it is compared one nanosecond after the pin changes, before any clock edge. Ignored writes, rejected writes and unstrobed bus activity are judged on the falling edge after the write. A later 60h write then shows whether the sequencer state was kept or dropped, and that too is checked one edge after it is sampled.

// File: rtl/sg_pkg.sv
package sg_pkg;

   typedef logic [7:0] cmd_t;

   localparam cmd_t CMD_LOCK = 8'h60;
   localparam cmd_t CMD_EXIT = 8'hF0;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_PRE1  = 2'd1,
      SEQ_ARMED = 2'd2
   } seq_state_t;

endpackage

// File: rtl/sg_cmd_seq.sv
module sg_cmd_seq #(
   parameter int ADDR_W  = 10,
   parameter int SECT_W  = 3,
   parameter int POL_BIT = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  sg_pkg::cmd_t          wr_data,
   input  logic                  erase_busy,
   output sg_pkg::seq_state_t    state,
   output logic                  apply,
   output logic [SECT_W-1:0]     apply_sect,
   output logic                  apply_unlock
);
   import sg_pkg::*;

   localparam int SECT_LSB = ADDR_W - SECT_W;

   seq_state_t nxt;
   logic       unused_addr_bits;

   assign apply_sect       = wr_addr[ADDR_W-1:SECT_LSB];
   assign apply_unlock     = wr_addr[POL_BIT];
   assign unused_addr_bits = ^wr_addr[SECT_LSB-1:0];

   always_comb begin
      nxt   = state;
      apply = 1'b0;
      if (wr_en) begin
         if (wr_data == CMD_EXIT) begin
            if (!erase_busy) nxt = SEQ_IDLE;
         end else if (wr_data != CMD_LOCK) begin
            nxt = SEQ_IDLE;
         end else begin
            unique case (state)
               SEQ_IDLE:  nxt = SEQ_PRE1;
               SEQ_PRE1:  nxt = SEQ_ARMED;
               SEQ_ARMED: begin
                  nxt   = SEQ_ARMED;
                  apply = 1'b1;
               end
               default:   nxt = SEQ_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEQ_IDLE;
      else        state <= nxt;
   end

endmodule

// File: rtl/sg_lock_bank.sv
module sg_lock_bank #(
   parameter int NUM_SECT = 8,
   parameter int SECT_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                apply,
   input  logic [SECT_W-1:0]   apply_sect,
   input  logic                apply_unlock,
   output logic [NUM_SECT-1:0] lock_bits
);

   for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
      logic hit;
      assign hit = apply && (apply_sect == SECT_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   lock_bits[i] <= 1'b1;
         else if (hit) lock_bits[i] <= ~apply_unlock;
      end
   end

endmodule

// File: rtl/sg_boot_mask.sv
module sg_boot_mask #(
   parameter int NUM_SECT = 8,
   parameter int BOOT_CNT = 2,
   parameter bit BOOT_TOP = 1'b1
) (
   input  logic                wp_n,
   input  logic [NUM_SECT-1:0] lock_bits,
   output logic [NUM_SECT-1:0] wr_ok
);

   logic [NUM_SECT-1:0] boot_sel;

   for (genvar i = 0; i < NUM_SECT; i++) begin : g_mask
      if (BOOT_TOP) begin : g_top
         assign boot_sel[i] = (i >= NUM_SECT - BOOT_CNT);
      end else begin : g_bot
         assign boot_sel[i] = (i < BOOT_CNT);
      end
      assign wr_ok[i] = ~lock_bits[i] & ~(boot_sel[i] & ~wp_n);
   end

endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
   parameter int ADDR_W   = 10,
   parameter int NUM_SECT = 8,
   parameter int POL_BIT  = 6,
   parameter int BOOT_CNT = 2,
   parameter bit BOOT_TOP = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [7:0]          wr_data,
   input  logic                wp_n,
   input  logic                erase_busy,
   output logic [NUM_SECT-1:0] lock_map,
   output logic [NUM_SECT-1:0] wr_ok
);
   import sg_pkg::*;

   localparam int SECT_W   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
   localparam int SECT_LSB = ADDR_W - SECT_W;

   if ((1 << SECT_W) != NUM_SECT) begin : g_bad_count
      $error("NUM_SECT must be a power of two");
   end
   if (POL_BIT >= SECT_LSB) begin : g_bad_pol
      $error("POL_BIT must lie below the sector field");
   end
   if (BOOT_CNT < 1 || BOOT_CNT > NUM_SECT) begin : g_bad_boot
      $error("BOOT_CNT out of range");
   end

   seq_state_t        fsm_state;
   logic              apply;
   logic [SECT_W-1:0] apply_sect;
   logic              apply_unlock;

   sg_cmd_seq #(
      .ADDR_W (ADDR_W),
      .SECT_W (SECT_W),
      .POL_BIT(POL_BIT)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .erase_busy  (erase_busy),
      .state       (fsm_state),
      .apply       (apply),
      .apply_sect  (apply_sect),
      .apply_unlock(apply_unlock)
   );

   sg_lock_bank #(
      .NUM_SECT(NUM_SECT),
      .SECT_W  (SECT_W)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .apply       (apply),
      .apply_sect  (apply_sect),
      .apply_unlock(apply_unlock),
      .lock_bits   (lock_map)
   );

   sg_boot_mask #(
      .NUM_SECT(NUM_SECT),
      .BOOT_CNT(BOOT_CNT),
      .BOOT_TOP(BOOT_TOP)
   ) u_mask (
      .wp_n     (wp_n),
      .lock_bits(lock_map),
      .wr_ok    (wr_ok)
   );

endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
   parameter int NUM_SECT = 8,
   parameter int SECT_W   = 3,
   parameter int BOOT_CNT = 2,
   parameter bit BOOT_TOP = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [7:0]          wr_data,
   input logic                wp_n,
   input logic                erase_busy,
   input logic [NUM_SECT-1:0] lock_map,
   input logic [NUM_SECT-1:0] wr_ok,
   input sg_pkg::seq_state_t  fsm_state,
   input logic                apply,
   input logic [SECT_W-1:0]   apply_sect,
   input logic                apply_unlock
);
   import sg_pkg::*;

   function automatic logic [NUM_SECT-1:0] boot_set();
      logic [NUM_SECT-1:0] m;
      m = '0;
      for (int k = 0; k < BOOT_CNT; k++) begin
         if (BOOT_TOP) m[NUM_SECT-1-k] = 1'b1;
         else          m[k] = 1'b1;
      end
      return m;
   endfunction

   localparam logic [NUM_SECT-1:0] BOOTS = boot_set();

   AST_MAP_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lock_map) |-> ($past(wr_en) && $past(wr_data) == CMD_LOCK)); // R2

   AST_ONE_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lock_map ^ $past(lock_map)) <= 1); // R4

   AST_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(apply) |-> (lock_map[$past(apply_sect)] == !$past(apply_unlock))); // R3

   AST_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == CMD_EXIT && !erase_busy) |=> fsm_state == SEQ_IDLE); // R5

   AST_EXIT_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == CMD_EXIT && erase_busy) |=> $stable(fsm_state)); // R6

   AST_BAD_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data != CMD_EXIT && wr_data != CMD_LOCK) |=> fsm_state == SEQ_IDLE); // R7

   AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(fsm_state) && $stable(lock_map))); // R10

   AST_WP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_n |-> ((wr_ok & BOOTS) == '0)); // R8

   AST_OK_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok & lock_map) == '0); // R9

endmodule

bind sector_guard sg_checker #(
   .NUM_SECT(NUM_SECT),
   .SECT_W  (SECT_W),
   .BOOT_CNT(BOOT_CNT),
   .BOOT_TOP(BOOT_TOP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .wp_n        (wp_n),
   .erase_busy  (erase_busy),
   .lock_map    (lock_map),
   .wr_ok       (wr_ok),
   .fsm_state   (fsm_state),
   .apply       (apply),
   .apply_sect  (apply_sect),
   .apply_unlock(apply_unlock)
);

// File: tb/sim_sector_guard.sv
`timescale 1ns/1ps
module sim_sector_guard;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [9:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       wp_n = 1'b1;
   logic       erase_busy = 1'b0;
   logic [7:0] lock_map;
   logic [7:0] wr_ok;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 0;

   logic [7:0] exp_lock;
   int         exp_st;

   always #10 clk = ~clk;

   sector_guard u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wp_n      (wp_n),
      .erase_busy(erase_busy),
      .lock_map  (lock_map),
      .wr_ok     (wr_ok)
   );

   function automatic logic [7:0] exp_ok();
      return ~exp_lock & ~(wp_n ? 8'h00 : 8'hC0);
   endfunction

   task automatic check(input string tag);
      n_chk++;
      if (lock_map !== exp_lock || wr_ok !== exp_ok()) begin
         n_fail++;
         $display("FAIL %s lock_map=%02h exp=%02h wr_ok=%02h exp=%02h",
                  tag, lock_map, exp_lock, wr_ok, exp_ok());
      end
   endtask

   function automatic logic [9:0] sa(input int s, input int pol);
      return {s[2:0], pol[0], 6'h15};
   endfunction

   task automatic wr(input logic [9:0] a, input logic [7:0] d, input string tag);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      if (d == 8'hF0) begin
         if (!erase_busy) exp_st = 0;
      end else if (d != 8'h60) begin
         exp_st = 0;
      end else if (exp_st == 2) begin
         exp_lock[a[9:7]] = ~a[6];
      end else begin
         exp_st = exp_st + 1;
      end
      @(negedge clk);
      wr_en = 1'b0;
      check(tag);
   endtask

   task automatic prefix(input string tag);
      wr(10'h3A5, 8'h60, tag);
      wr(10'h04B, 8'h60, tag);
   endtask

   initial begin
      exp_lock = 8'hFF;
      exp_st   = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");

      for (int s = 0; s < 8; s++) begin
         for (int p = 0; p < 2; p++) begin
            wr(10'h3FF, 8'hF0, "R5");
            prefix("R2");
            wr(sa(s, p), 8'h60, "R3");
         end
      end

      wr(10'h000, 8'hF0, "R5");
      prefix("R2");
      for (int s = 0; s < 8; s++) wr(sa(s, 1), 8'h60, "R4");
      for (int s = 0; s < 8; s += 2) wr(sa(s, 0), 8'h60, "R4");

      wr(10'h155, 8'hF0, "R5");
      wr(sa(1, 0), 8'h60, "R5");
      wr(sa(3, 0), 8'h60, "R5");
      wr(sa(5, 0), 8'h60, "R5");

      erase_busy = 1'b1;
      wr(10'h2AA, 8'hF0, "R6");
      wr(sa(7, 0), 8'h60, "R6");
      erase_busy = 1'b0;

      wr(10'h111, 8'h55, "R7");
      wr(sa(0, 1), 8'h60, "R7");
      wr(10'h222, 8'hA0, "R7");
      wr(sa(0, 1), 8'h60, "R7");
      wr(sa(0, 1), 8'h60, "R7");
      wr(sa(2, 1), 8'h60, "R7");
      wr(sa(4, 1), 8'h60, "R7");

      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         wr_addr = sa(k, k & 1); wr_data = 8'h60;
      end
      @(negedge clk);
      check("R10");
      wr(sa(6, 1), 8'h60, "R10");

      for (int pat = 0; pat < 256; pat++) begin
         for (int s = 0; s < 8; s++) wr(sa(s, pat[s] ? 0 : 1), 8'h60, "R9");
         wp_n = 1'b0; #1; check("R8");
         wp_n = 1'b1; #1; check("R8");
      end

      wp_n = 1'b0;
      prefix("R8");
      wr(sa(7, 1), 8'h60, "R8");
      wr(sa(6, 1), 8'h60, "R8");
      wp_n = 1'b1; #1; check("R8");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired before completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule